// File: doc/BRIEF.md
# Multiplexed Burst Local-Bus Master

This block is the master side of a shared 32-bit local bus on which address and data take turns on the same wires. An internal requester hands it one transaction at a time: a read, a write, a locked read-modify-write pair, or an interrupt acknowledge, each one to four words long. The controller runs an address state, then data states that stretch by wait states until the external ready input is seen. It also idles and yields the bus in a hold state when another master asks for it.

In the address state the word address goes out on the upper bits and the burst length code goes out on the two low bits. The strobes show the slave what is happening: address latch, address/data status, write/read, transfer direction and data enable. The block does not model the pads. Each driven group has an output-enable, and the shared lock line is split into an observed input and a pull-low enable. All state changes happen on the internal clock enable, which by default is one edge in two of the doubled input clock.

A read-modify-write first waits for the lock line to be free. It then takes the lock for the read and releases it as the write to the same address starts. An interrupt acknowledge holds the lock for its whole transaction.

Top module: `lbm_bus_master`

## Requirements
- R1: After reset the block is idle with the bus released: lad_oe=0, ale_oe=1, ale_n, as_n and den_n high, lock_pull=0, hold_ack=0, rd_valid=0, req_ready=1.
- R2: With CLK_DIV=2 the bus state changes only on every second rising edge of clk2x. A request seen on one edge produces no address state on the edge that follows it.
- R3: In the address state lad_out = {word address, length code}, where the code in bits [1:0] is 00 for 1 word, 01 for 2, 10 for 3 and 11 for 4. In that state ale_n=0, as_n=0 and lad_oe=1.
- R4: ale_n is high and den_n is low in every data and wait state. ale_n and den_n are never low together.
- R5: as_n is low in a data state that directly follows a non-final data state in which ready_n was sampled low. It is high in the first data state after the address state.
- R6: A data state in which ready_n is high is repeated as a wait state. The next state has as_n high and rd_valid low, and no beat is counted.
- R7: A transaction ends after length-code+1 accepted beats and the block returns to idle. Each accepted read beat shows lad_in on rd_data with rd_valid high for one internal cycle.
- R8: Request kind is coded on req_kind as 00 read, 01 write, 10 read-modify-write, 11 interrupt acknowledge. wr_sel and dir_tx are high from the address state through the data states of a write and low for a read or interrupt acknowledge. A write drives word n of req_wdata (bits n*32 upward) with lad_oe=1 in beat n; a read keeps lad_oe=0 in data states.
- R9: dir_tx never changes while den_n stays low.
- R10: A read-modify-write stays out of the address state while lock_in_n is low. It raises lock_pull in the read's address state, keeps it through the read beats, drops it in the write's address state, and then writes to the same address with wr_sel=1.
- R11: An interrupt acknowledge has lock_pull high from its address state through its last data state and low again in idle.
- R12: While hold_req is high in idle, the block enters hold: hold_ack=1, lad_oe=0, ale_oe=0, req_ready=0, and no request starts until hold_req falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Doubled input clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Request kind code |
| req_addr | input | 30 | Word address |
| req_len | input | 2 | Burst length code (words minus one) |
| req_wdata | input | 128 | Write words, word 0 in the low bits |
| req_ready | output | 1 | Block can take a request this cycle |
| rd_data | output | 32 | Captured read beat |
| rd_valid | output | 1 | rd_data holds a new beat |
| lad_in | input | 32 | Bus value seen at the pads |
| lad_out | output | 32 | Bus value to drive |
| lad_oe | output | 1 | Drive enable for lad_out |
| ale_n | output | 1 | Address latch enable, active low |
| ale_oe | output | 1 | Drive enable for ale_n |
| as_n | output | 1 | Address/data status strobe, active low |
| wr_sel | output | 1 | High for a write transaction |
| dir_tx | output | 1 | Transfer direction, high when transmitting |
| den_n | output | 1 | Data enable, active low |
| ready_n | input | 1 | Slave ready, active low |
| lock_in_n | input | 1 | Observed shared lock line, active low |
| lock_pull | output | 1 | Pull the shared lock line low |
| hold_req | input | 1 | Another master requests the bus |
| hold_ack | output | 1 | Bus yielded |

## Verification
The bench builds the block with its defaults: 32-bit data, a two-bit length code and CLK_DIV=2. With these values it can check the half-rate stepping of R2 edge by edge and run every length code from one to four words. The bench mixes zero, one and two wait states per beat, so the status re-assertion after accepted beats can be told apart from the suppression after a wait. The full 30-bit address field, including all-ones, is also reached, which checks that the length code never corrupts the address bits.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
   typedef enum logic [1:0] {
      K_READ  = 2'd0,
      K_WRITE = 2'd1,
      K_RMW   = 2'd2,
      K_INTA  = 2'd3
   } lbm_kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_LKWAIT,
      S_ADDR,
      S_DATA,
      S_HOLD
   } lbm_state_e;
endpackage

// File: rtl/lbm_tick_gen.sv
module lbm_tick_gen #(
   parameter int CLK_DIV = 2
) (
   input  logic clk2x,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLK_DIV == 2) begin : g_half
         logic phase_q;
         always_ff @(posedge clk2x or negedge rst_n) begin
            if (!rst_n) phase_q <= 1'b0;
            else        phase_q <= ~phase_q;
         end
         assign tick = phase_q;
      end else begin : g_full
         assign tick = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lbm_beat_ctr.sv
module lbm_beat_ctr #(
   parameter int LEN_W = 2
) (
   input  logic             clk2x,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [LEN_W-1:0] len_in,
   input  logic             adv,
   output logic [LEN_W-1:0] idx,
   output logic             last
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] lim_q;

   always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (tick) begin
         if (load) begin
            cnt_q <= '0;
            lim_q <= len_in;
         end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign idx  = cnt_q;
   assign last = (cnt_q == lim_q);
endmodule

// File: rtl/lbm_bus_master.sv
module lbm_bus_master
   import lbm_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 2,
   parameter int CLK_DIV = 2,
   localparam int ADDR_W = DATA_W - LEN_W,
   localparam int MAXB   = 1 << LEN_W,
   localparam int WBUF_W = MAXB * DATA_W
) (
   input  logic              clk2x,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [WBUF_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   input  logic [DATA_W-1:0] lad_in,
   output logic [DATA_W-1:0] lad_out,
   output logic              lad_oe,
   output logic              ale_n,
   output logic              ale_oe,
   output logic              as_n,
   output logic              wr_sel,
   output logic              dir_tx,
   output logic              den_n,
   input  logic              ready_n,
   input  logic              lock_in_n,
   output logic              lock_pull,
   input  logic              hold_req,
   output logic              hold_ack
);
   initial begin
      if (CLK_DIV != 1 && CLK_DIV != 2)
         $fatal(1, "lbm_bus_master: CLK_DIV must be 1 or 2");
      if (LEN_W < 1 || LEN_W >= DATA_W)
         $fatal(1, "lbm_bus_master: LEN_W out of range");
   end

   logic              tick;
   lbm_state_e        state_q, state_d;
   lbm_kind_e         kind_q, cur_kind;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic [WBUF_W-1:0] wbuf_q;
   logic              second_q, wr_q, lock_q, rdy_prev_q;
   logic [DATA_W-1:0] rd_data_q;
   logic              rd_valid_q;
   logic [LEN_W-1:0]  beat_idx;
   logic              beat_last, beat_ok, enter_addr;

   lbm_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk2x(clk2x), .rst_n(rst_n), .tick(tick)
   );

   lbm_beat_ctr #(.LEN_W(LEN_W)) u_beats (
      .clk2x(clk2x), .rst_n(rst_n), .tick(tick),
      .load(state_q == S_ADDR), .len_in(len_q), .adv(beat_ok),
      .idx(beat_idx), .last(beat_last)
   );

   assign beat_ok    = (state_q == S_DATA) && !ready_n;
   assign cur_kind   = (state_q == S_IDLE) ? lbm_kind_e'(req_kind) : kind_q;
   assign enter_addr = (state_d == S_ADDR) && (state_q != S_ADDR);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE: begin
            if (hold_req)
               state_d = S_HOLD;
            else if (req_valid)
               state_d = (req_kind == K_RMW && !lock_in_n) ? S_LKWAIT : S_ADDR;
         end
         S_LKWAIT: if (lock_in_n) state_d = S_ADDR;
         S_ADDR:   state_d = S_DATA;
         S_DATA: begin
            if (beat_ok && beat_last)
               state_d = (kind_q == K_RMW && !second_q) ? S_ADDR : S_IDLE;
         end
         S_HOLD:   if (!hold_req) state_d = S_IDLE;
         default:  state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         kind_q     <= K_READ;
         addr_q     <= '0;
         len_q      <= '0;
         wbuf_q     <= '0;
         second_q   <= 1'b0;
         wr_q       <= 1'b0;
         lock_q     <= 1'b0;
         rdy_prev_q <= 1'b0;
         rd_data_q  <= '0;
         rd_valid_q <= 1'b0;
      end else if (tick) begin
         state_q    <= state_d;
         rdy_prev_q <= beat_ok && !beat_last;
         rd_valid_q <= beat_ok && !wr_q;
         if (beat_ok && !wr_q) rd_data_q <= lad_in;
         if (state_q == S_IDLE && req_valid && !hold_req) begin
            kind_q   <= lbm_kind_e'(req_kind);
            addr_q   <= req_addr;
            len_q    <= req_len;
            wbuf_q   <= req_wdata;
            second_q <= 1'b0;
         end
         if (enter_addr) begin
            if (state_q == S_DATA) begin
               second_q <= 1'b1;
               wr_q     <= 1'b1;
               lock_q   <= 1'b0;
            end else begin
               wr_q   <= (cur_kind == K_WRITE);
               lock_q <= (cur_kind == K_RMW) || (cur_kind == K_INTA);
            end
         end else if (state_q == S_DATA && state_d == S_IDLE) begin
            lock_q <= 1'b0;
         end
      end
   end

   assign lad_out   = (state_q == S_ADDR) ? {addr_q, len_q}
                                          : wbuf_q[beat_idx*DATA_W +: DATA_W];
   assign lad_oe    = (state_q == S_ADDR) || (state_q == S_DATA && wr_q);
   assign ale_n     = (state_q != S_ADDR);
   assign ale_oe    = (state_q != S_HOLD);
   assign as_n      = !((state_q == S_ADDR) || (state_q == S_DATA && rdy_prev_q));
   assign den_n     = (state_q != S_DATA);
   assign wr_sel    = wr_q;
   assign dir_tx    = wr_q;
   assign lock_pull = lock_q;
   assign hold_ack  = (state_q == S_HOLD);
   assign req_ready = (state_q == S_IDLE) && !hold_req;
   assign rd_data   = rd_data_q;
   assign rd_valid  = rd_valid_q;
endmodule

// File: rtl/lbm_chk.sv
module lbm_chk (
   input logic clk2x,
   input logic rst_n,
   input logic ale_n,
   input logic ale_oe,
   input logic as_n,
   input logic den_n,
   input logic dir_tx,
   input logic wr_sel,
   input logic lad_oe,
   input logic lock_pull,
   input logic hold_ack
);
   assert_addr_status_R3: assert property (@(posedge clk2x) disable iff (!rst_n)
      !ale_n |-> (!as_n && lad_oe));

   assert_ale_den_excl_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
      !(!ale_n && !den_n));

   assert_data_drive_write_R8: assert property (@(posedge clk2x) disable iff (!rst_n)
      (lad_oe && !den_n) |-> wr_sel);

   assert_dir_stable_R9: assert property (@(posedge clk2x) disable iff (!rst_n)
      (!den_n && $past(!den_n)) |-> $stable(dir_tx));

   assert_lock_in_addr_R10: assert property (@(posedge clk2x) disable iff (!rst_n)
      $rose(lock_pull) |-> !ale_n);

   assert_hold_float_R12: assert property (@(posedge clk2x) disable iff (!rst_n)
      hold_ack |-> (!lad_oe && !ale_oe && den_n));
endmodule

bind lbm_bus_master lbm_chk u_chk (
   .clk2x(clk2x), .rst_n(rst_n), .ale_n(ale_n), .ale_oe(ale_oe),
   .as_n(as_n), .den_n(den_n), .dir_tx(dir_tx), .wr_sel(wr_sel),
   .lad_oe(lad_oe), .lock_pull(lock_pull), .hold_ack(hold_ack)
);

// File: tb/sim_lbm_bus_master.sv
module sim_lbm_bus_master;
   localparam time CLK_P = 10ns;

   logic         clk2x = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [1:0]   req_kind = 2'd0;
   logic [29:0]  req_addr = '0;
   logic [1:0]   req_len = '0;
   logic [127:0] req_wdata = '0;
   logic         req_ready;
   logic [31:0]  rd_data;
   logic         rd_valid;
   logic [31:0]  lad_in = '0;
   logic [31:0]  lad_out;
   logic         lad_oe, ale_n, ale_oe, as_n, wr_sel, dir_tx, den_n;
   logic         ready_n = 1'b1;
   logic         lock_in_n = 1'b1;
   logic         lock_pull;
   logic         hold_req = 1'b0;
   logic         hold_ack;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk2x = ~clk2x;

   lbm_bus_master u0 (
      .clk2x(clk2x), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
      .req_ready(req_ready), .rd_data(rd_data), .rd_valid(rd_valid),
      .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe), .ale_n(ale_n),
      .ale_oe(ale_oe), .as_n(as_n), .wr_sel(wr_sel), .dir_tx(dir_tx),
      .den_n(den_n), .ready_n(ready_n), .lock_in_n(lock_in_n),
      .lock_pull(lock_pull), .hold_req(hold_req), .hold_ack(hold_ack)
   );

   // kind, address, length code, data seed, wait states per beat
   localparam logic [67:0] VEC [0:5] = '{
      {2'd0, 30'h0000_1234, 2'd0, 32'hA000_0000, 2'd0},
      {2'd0, 30'h0ABC_DEF0, 2'd3, 32'h1111_0000, 2'd0},
      {2'd1, 30'h0000_0040, 2'd1, 32'hC0DE_0000, 2'd1},
      {2'd0, 30'h3FFF_FFFF, 2'd2, 32'h5A5A_0000, 2'd2},
      {2'd3, 30'h0000_0000, 2'd0, 32'h0000_00FF, 2'd1},
      {2'd1, 30'h1555_5555, 2'd3, 32'hFFFF_FFF0, 2'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic edge1();
      @(posedge clk2x);
      #1;
   endtask

   task automatic tick();
      edge1();
      edge1();
   endtask

   task automatic run_txn(input logic [1:0] k, input logic [29:0] a, input logic [1:0] l,
                          input logic [31:0] s, input int w);
      logic wr;
      wr = (k == 2'd1);
      req_valid = 1'b1;
      req_kind  = k;
      req_addr  = a;
      req_len   = l;
      for (int b = 0; b < 4; b++) req_wdata[b*32 +: 32] = s + b;
      ready_n = 1'b1;
      tick();
      req_valid = 1'b0;
      chk("R3 ale_n in address", ale_n, 0);
      chk("R3 as_n in address", as_n, 0);
      chk("R3 address and length", lad_out, {a, l});
      chk("R3 lad_oe in address", lad_oe, 1);
      chk("R8 wr_sel", wr_sel, wr);
      chk("R8 dir_tx", dir_tx, wr);
      chk("R4 den_n in address", den_n, 1);
      chk("R11 lock in address", lock_pull, k == 2'd3);
      tick();
      chk("R4 ale_n in data", ale_n, 1);
      chk("R4 den_n in data", den_n, 0);
      for (int b = 0; b <= int'(l); b++) begin
         chk("R5 as_n on beat entry", as_n, b == 0);
         for (int i = 0; i < w; i++) begin
            ready_n = 1'b1;
            tick();
            chk("R6 as_n after wait", as_n, 1);
            chk("R6 den_n in wait", den_n, 0);
            chk("R6 no read beat in wait", rd_valid, 0);
         end
         if (wr) begin
            chk("R8 write beat data", lad_out, s + b);
            chk("R8 write beat drive", lad_oe, 1);
         end else begin
            chk("R8 read beat no drive", lad_oe, 0);
         end
         ready_n = 1'b0;
         lad_in  = s + b;
         tick();
         if (!wr) begin
            chk("R7 rd_valid", rd_valid, 1);
            chk("R7 rd_data", rd_data, s + b);
         end
         if (k == 2'd3) chk("R11 lock through beats", lock_pull, b < int'(l));
      end
      ready_n = 1'b1;
      chk("R7 idle den_n", den_n, 1);
      chk("R7 idle as_n", as_n, 1);
      chk("R7 idle req_ready", req_ready, 1);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R7 actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk2x);
      #1 rst_n = 1'b1;
      chk("R1 lad_oe", lad_oe, 0);
      chk("R1 ale_oe", ale_oe, 1);
      chk("R1 ale_n", ale_n, 1);
      chk("R1 as_n", as_n, 1);
      chk("R1 den_n", den_n, 1);
      chk("R1 lock_pull", lock_pull, 0);
      chk("R1 hold_ack", hold_ack, 0);
      chk("R1 rd_valid", rd_valid, 0);
      chk("R1 req_ready", req_ready, 1);

      foreach (VEC[i])
         run_txn(VEC[i][67:66], VEC[i][65:36], VEC[i][35:34], VEC[i][33:2], int'(VEC[i][1:0]));

      // R2: half-rate stepping
      req_valid = 1'b1; req_kind = 2'd0; req_addr = 30'h0000_0777; req_len = 2'd0;
      edge1();
      chk("R2 no step on odd edge", ale_n, 1);
      edge1();
      chk("R2 step on even edge", ale_n, 0);
      req_valid = 1'b0;
      ready_n = 1'b0; lad_in = 32'h2222_3333;
      tick();
      tick();
      chk("R2 single beat read", rd_data, 32'h2222_3333);
      ready_n = 1'b1;

      // R10: locked read-modify-write
      lock_in_n = 1'b0;
      req_valid = 1'b1; req_kind = 2'd2; req_addr = 30'h0000_0ACE; req_len = 2'd0;
      req_wdata = {96'h0, 32'hBEEF_0001};
      tick();
      req_valid = 1'b0;
      chk("R10 waits for lock free", ale_n, 1);
      chk("R10 no lock while waiting", lock_pull, 0);
      tick();
      chk("R10 still waiting", ale_n, 1);
      lock_in_n = 1'b1;
      tick();
      chk("R10 read address state", ale_n, 0);
      chk("R10 lock taken", lock_pull, 1);
      chk("R10 read direction", wr_sel, 0);
      ready_n = 1'b0; lad_in = 32'h0000_5151;
      tick();
      chk("R10 lock held in read data", lock_pull, 1);
      tick();
      chk("R10 write address state", ale_n, 0);
      chk("R10 lock released", lock_pull, 0);
      chk("R10 write selected", wr_sel, 1);
      chk("R10 same address", lad_out, {30'h0000_0ACE, 2'd0});
      chk("R10 read data returned", rd_data, 32'h0000_5151);
      tick();
      chk("R10 write data", lad_out, 32'hBEEF_0001);
      tick();
      chk("R10 back to idle", den_n, 1);
      ready_n = 1'b1;

      // R12: hold
      hold_req = 1'b1;
      tick();
      chk("R12 hold_ack", hold_ack, 1);
      chk("R12 ale_oe", ale_oe, 0);
      chk("R12 lad_oe", lad_oe, 0);
      chk("R12 req_ready", req_ready, 0);
      req_valid = 1'b1; req_kind = 2'd0; req_addr = 30'h0000_0003; req_len = 2'd0;
      tick();
      chk("R12 request not started", ale_n, 1);
      hold_req = 1'b0;
      tick();
      chk("R12 released to idle", hold_ack, 0);
      tick();
      req_valid = 1'b0;
      chk("R12 request starts after hold", ale_n, 0);
      ready_n = 1'b0;
      tick();
      tick();
      ready_n = 1'b1;
      chk("R12 request completes", den_n, 1);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule